// File: doc/BRIEF.md
# Wake Event Output Router

This block decides what appears on one shared wake pin. The pin is active low and open drain. Configuration bits choose what the pin carries. It can carry a power-management event (PME) raised by the block's own status flag, or the ring-indicate line of a 16-bit I/O card. Ring-indicate can also be moved to a separate auxiliary output. PME and ring then reach the system as two independent signals.

The block holds the PME enable bit and the PME status bit. A rising edge on a wake request input sets the status bit, and software clears it by writing a one. Two resets act on these bits. The global reset always clears them. The bus reset spares them while PME is enabled, so wake context survives a bus reset taken during a low-power state. The card's ring line is asynchronous and passes through a two-stage synchronizer before it can reach either output.

Top module: `wake_router`

## Requirements
- R1: After global reset (`glob_rst_n` low for at least one clock), `pme_en_o`, `pme_stat_o`, `wake_pull_low` and `aux_ring` are all 0.
- R2: With `sel_ri_mode`=1, `ri_en`=1 and `ri_to_aux`=0, `wake_pull_low` equals `card_ring` delayed by two clock edges.
- R3: With `sel_ri_mode`=1, ring not placed on the pin (`ri_en`=0 or `ri_to_aux`=1) and `pme_en_o`=1, `wake_pull_low` equals `pme_stat_o`.
- R4: With `sel_ri_mode`=1, ring not placed on the pin and `pme_en_o`=0, `wake_pull_low` is 0 whatever the status bit and ring line do.
- R5: With `sel_ri_mode`=0, `wake_pull_low` equals `pme_en_o & pme_stat_o`, and `card_ring` has no effect on it.
- R6: A 0-to-1 transition on `wake_req`, sampled on the clock, sets `pme_stat_o` one edge later. A level held high does not set it again after a clear.
- R7: `stat_clr`=1 for one cycle clears `pme_stat_o` at the next edge. If a new wake edge arrives in the same cycle, setting wins.
- R8: While `bus_rst_n` is low and `pme_en_o`=1, the enable and status bits hold their values. While `bus_rst_n` is low and `pme_en_o`=0, the status bit is cleared. Writes and wake edges are ignored during bus reset.
- R9: A global reset clears the enable and status bits even when PME is enabled.
- R10: With `ri_en`=1 and `ri_to_aux`=1, `aux_ring` equals `card_ring` delayed by two clock edges, and the ring is never on `wake_pull_low`. Otherwise `aux_ring` is 0.
- R11: `wake_pull_low`=1 means the pad pulls the shared line low (event asserted). 0 means the line is released. The block has no way to drive the line high.
- R12: `en_wr`=1 loads `en_wr_val` into `pme_en_o` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| glob_rst_n | input | 1 | Global reset, active low, synchronous |
| bus_rst_n | input | 1 | Bus reset, active low, synchronous |
| sel_ri_mode | input | 1 | 1: shared pin in ring mode, 0: PME mode |
| ri_en | input | 1 | Ring-indicate enable |
| ri_to_aux | input | 1 | Steer ring to the auxiliary output |
| en_wr | input | 1 | Write strobe for the PME enable bit |
| en_wr_val | input | 1 | Value written to the PME enable bit |
| stat_clr | input | 1 | Write-one-to-clear strobe for PME status |
| wake_req | input | 1 | Wake request; rising edge sets PME status |
| card_ring | input | 1 | Asynchronous ring line from the card |
| wake_pull_low | output | 1 | Open-drain pull-down enable for the shared wake pin |
| aux_ring | output | 1 | Synchronized ring on the auxiliary pin |
| pme_en_o | output | 1 | PME enable bit |
| pme_stat_o | output | 1 | PME status bit |

## Verification
Assertions check on every cycle that the ring never appears on both outputs, and that the pin stays released when no source is selected. They also check that a wake edge sets the status bit, that a clear strobe with no wake edge drops it, and that enabled context holds through a bus reset. The bench's scenarios are needed to show the two-edge latency of the ring path and the full priority order across mode changes. They also show that a held wake level does not re-arm, and that a global reset overrides enabled context.

// File: rtl/wk_pkg.sv
package wk_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RING = 2'd1,
    SRC_STAT = 2'd2
  } wk_src_e;

  // Source priority for the shared pin: ring first (ring mode only), then PME.
  function automatic wk_src_e pick_src(input logic ri_mode, input logic ri_en,
                                       input logic ri_aux, input logic pme_en);
    if (ri_mode && ri_en && !ri_aux) return SRC_RING;
    if (pme_en) return SRC_STAT;
    return SRC_NONE;
  endfunction

  function automatic logic aux_sel(input logic ri_en, input logic ri_aux);
    return ri_en && ri_aux;
  endfunction

endpackage

// File: rtl/wk_ring_sync.sv
module wk_ring_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

  // R2: output only moves after the previous stage held the new value
  p_sync_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chain[STAGES-1] != $past(chain[STAGES-1])) |-> (chain[STAGES-1] == $past(chain[STAGES-2 < 0 ? 0 : STAGES-2])));
endmodule

// File: rtl/wk_pme_regs.sv
module wk_pme_regs (
  input  logic clk,
  input  logic glob_rst_n,
  input  logic bus_rst_n,
  input  logic en_wr,
  input  logic en_wr_val,
  input  logic stat_clr,
  input  logic wake_req,
  output logic pme_en,
  output logic pme_stat,
  output logic wake_edge
);
  logic wake_q;

  always_ff @(posedge clk) begin
    if (!glob_rst_n) wake_q <= 1'b0;
    else             wake_q <= wake_req;
  end

  assign wake_edge = wake_req && !wake_q;

  always_ff @(posedge clk) begin
    if (!glob_rst_n) begin
      pme_en   <= 1'b0;
      pme_stat <= 1'b0;
    end else if (!bus_rst_n) begin
      if (!pme_en) pme_stat <= 1'b0;
    end else begin
      if (en_wr) pme_en <= en_wr_val;
      if (wake_edge)     pme_stat <= 1'b1;
      else if (stat_clr) pme_stat <= 1'b0;
    end
  end

  p_stat_set_r6: assert property (@(posedge clk) disable iff (!glob_rst_n || !bus_rst_n)
    wake_edge |=> pme_stat);

  p_w1c_r7: assert property (@(posedge clk) disable iff (!glob_rst_n || !bus_rst_n)
    (stat_clr && !wake_edge) |=> !pme_stat);

  p_bus_keep_r8: assert property (@(posedge clk) disable iff (!glob_rst_n)
    (!bus_rst_n && pme_en) |=> (pme_en && $stable(pme_stat)));

  p_bus_drop_r8: assert property (@(posedge clk) disable iff (!glob_rst_n)
    (!bus_rst_n && !pme_en) |=> (!pme_en && !pme_stat));
endmodule

// File: rtl/wk_pin_mux.sv
module wk_pin_mux
  import wk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ri_mode,
  input  logic ri_en,
  input  logic ri_aux,
  input  logic pme_en,
  input  logic pme_stat,
  input  logic ring_s,
  output logic pull_low,
  output logic aux_out,
  output logic ring_on_pin
);
  wk_src_e src;

  always_comb begin
    src = pick_src(ri_mode, ri_en, ri_aux, pme_en);
    unique case (src)
      SRC_RING: pull_low = ring_s;
      SRC_STAT: pull_low = pme_stat;
      default:  pull_low = 1'b0;
    endcase
    aux_out     = aux_sel(ri_en, ri_aux) && ring_s;
    ring_on_pin = (src == SRC_RING);
  end

  // R10: ring never selected for both outputs at once
  p_aux_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    aux_out |-> !ring_on_pin);

  // R4: nothing selected means the line is released
  p_idle_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ring_on_pin && !pme_en) |-> !pull_low);

  // R5: in PME mode the line is only pulled with enable and status both set
  p_pme_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ri_mode && pull_low) |-> (pme_en && pme_stat));
endmodule

// File: rtl/wake_router.sv
module wake_router #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic glob_rst_n,
  input  logic bus_rst_n,
  input  logic sel_ri_mode,
  input  logic ri_en,
  input  logic ri_to_aux,
  input  logic en_wr,
  input  logic en_wr_val,
  input  logic stat_clr,
  input  logic wake_req,
  input  logic card_ring,
  output logic wake_pull_low,
  output logic aux_ring,
  output logic pme_en_o,
  output logic pme_stat_o
);
  logic ring_s;
  logic wake_edge;
  logic ring_on_pin;

  wk_ring_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(glob_rst_n),
    .din  (card_ring),
    .dout (ring_s)
  );

  wk_pme_regs u_regs (
    .clk       (clk),
    .glob_rst_n(glob_rst_n),
    .bus_rst_n (bus_rst_n),
    .en_wr     (en_wr),
    .en_wr_val (en_wr_val),
    .stat_clr  (stat_clr),
    .wake_req  (wake_req),
    .pme_en    (pme_en_o),
    .pme_stat  (pme_stat_o),
    .wake_edge (wake_edge)
  );

  wk_pin_mux u_mux (
    .clk        (clk),
    .rst_n      (glob_rst_n),
    .ri_mode    (sel_ri_mode),
    .ri_en      (ri_en),
    .ri_aux     (ri_to_aux),
    .pme_en     (pme_en_o),
    .pme_stat   (pme_stat_o),
    .ring_s     (ring_s),
    .pull_low   (wake_pull_low),
    .aux_out    (aux_ring),
    .ring_on_pin(ring_on_pin)
  );

  // R9: global reset leaves no context behind
  p_glob_clear_r9: assert property (@(posedge clk)
    !glob_rst_n |=> (!pme_en_o && !pme_stat_o));

  // R12: enable write lands on the next edge outside bus reset
  p_en_write_r12: assert property (@(posedge clk) disable iff (!glob_rst_n || !bus_rst_n)
    en_wr |=> (pme_en_o == $past(en_wr_val)));
endmodule

// File: tb/wake_router_bench.sv
module wake_router_bench;
  logic clk = 1'b0;
  logic glob_rst_n, bus_rst_n, sel_ri_mode, ri_en, ri_to_aux;
  logic en_wr, en_wr_val, stat_clr, wake_req, card_ring;
  logic wake_pull_low, aux_ring, pme_en_o, pme_stat_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wake_router u_wake_router (
    .clk(clk), .glob_rst_n(glob_rst_n), .bus_rst_n(bus_rst_n),
    .sel_ri_mode(sel_ri_mode), .ri_en(ri_en), .ri_to_aux(ri_to_aux),
    .en_wr(en_wr), .en_wr_val(en_wr_val), .stat_clr(stat_clr),
    .wake_req(wake_req), .card_ring(card_ring),
    .wake_pull_low(wake_pull_low), .aux_ring(aux_ring),
    .pme_en_o(pme_en_o), .pme_stat_o(pme_stat_o)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic glob_reset();
    glob_rst_n = 1'b0; step(2); glob_rst_n = 1'b1;
  endtask

  task automatic set_en(input logic v);
    en_wr = 1'b1; en_wr_val = v; step(1); en_wr = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_req = 1'b1; step(1); wake_req = 1'b0; step(1);
  endtask

  task automatic t_reset();
    glob_reset();
    chk(pme_en_o, 1'b0, "R1 enable after reset");
    chk(pme_stat_o, 1'b0, "R1 status after reset");
    chk(wake_pull_low, 1'b0, "R1 pin after reset");
    chk(aux_ring, 1'b0, "R1 aux after reset");
  endtask

  task automatic t_ring_follow();
    sel_ri_mode = 1'b1; ri_en = 1'b1; ri_to_aux = 1'b0;
    card_ring = 1'b1; step(1);
    chk(wake_pull_low, 1'b0, "R2 ring after one edge");
    step(1);
    chk(wake_pull_low, 1'b1, "R2 ring after two edges");
    chk(aux_ring, 1'b0, "R10 aux off when ring on pin");
    card_ring = 1'b0; step(2);
    chk(wake_pull_low, 1'b0, "R2 ring released");
  endtask

  task automatic t_ring_fallback();
    set_en(1'b1);
    chk(pme_en_o, 1'b1, "R12 enable written");
    sel_ri_mode = 1'b1; ri_en = 1'b0; card_ring = 1'b1; step(2);
    chk(wake_pull_low, 1'b0, "R3 status low, ring ignored");
    pulse_wake();
    chk(wake_pull_low, 1'b1, "R3 pin follows status");
    stat_clr = 1'b1; step(1); stat_clr = 1'b0;
    chk(wake_pull_low, 1'b0, "R3 pin follows cleared status");
    card_ring = 1'b0; step(2);
  endtask

  task automatic t_both_off();
    pulse_wake();
    set_en(1'b0);
    sel_ri_mode = 1'b1; ri_en = 1'b0; card_ring = 1'b1; step(3);
    chk(pme_stat_o, 1'b1, "R4 status still set");
    chk(wake_pull_low, 1'b0, "R4 pin released with both off");
    card_ring = 1'b0; stat_clr = 1'b1; step(1); stat_clr = 1'b0; step(2);
  endtask

  task automatic t_pme_mode();
    sel_ri_mode = 1'b0; ri_en = 1'b1; ri_to_aux = 1'b0;
    card_ring = 1'b1; step(3);
    chk(wake_pull_low, 1'b0, "R5 ring ignored in PME mode");
    pulse_wake();
    chk(wake_pull_low, 1'b0, "R5 status without enable");
    set_en(1'b1);
    chk(wake_pull_low, 1'b1, "R5 enable and status");
    card_ring = 1'b0; stat_clr = 1'b1; step(1); stat_clr = 1'b0; step(2);
  endtask

  task automatic t_edge_set();
    wake_req = 1'b1; step(1);
    chk(pme_stat_o, 1'b1, "R6 set on rising edge");
    stat_clr = 1'b1; step(1); stat_clr = 1'b0; step(2);
    chk(pme_stat_o, 1'b0, "R6 held level does not re-set");
    wake_req = 1'b0; step(1);
  endtask

  task automatic t_w1c();
    wake_req = 1'b1; stat_clr = 1'b1; step(1);
    chk(pme_stat_o, 1'b1, "R7 set wins over clear");
    wake_req = 1'b0; step(1);
    chk(pme_stat_o, 1'b0, "R7 clear strobe");
    stat_clr = 1'b0;
  endtask

  task automatic t_bus_reset();
    set_en(1'b1); pulse_wake();
    bus_rst_n = 1'b0; en_wr = 1'b1; en_wr_val = 1'b0; step(3);
    en_wr = 1'b0; bus_rst_n = 1'b1;
    chk(pme_en_o, 1'b1, "R8 enable survives bus reset");
    chk(pme_stat_o, 1'b1, "R8 status survives bus reset");
    set_en(1'b0);
    bus_rst_n = 1'b0; step(1); bus_rst_n = 1'b1;
    chk(pme_stat_o, 1'b0, "R8 status cleared when disabled");
  endtask

  task automatic t_glob_reset();
    set_en(1'b1); pulse_wake();
    glob_reset();
    chk(pme_en_o, 1'b0, "R9 global clears enable");
    chk(pme_stat_o, 1'b0, "R9 global clears status");
  endtask

  task automatic t_aux_route();
    set_en(1'b1);
    sel_ri_mode = 1'b1; ri_en = 1'b1; ri_to_aux = 1'b1;
    card_ring = 1'b1; step(1);
    chk(aux_ring, 1'b0, "R10 aux after one edge");
    step(1);
    chk(aux_ring, 1'b1, "R10 aux after two edges");
    chk(wake_pull_low, 1'b0, "R10 ring kept off shared pin");
    pulse_wake();
    chk(wake_pull_low, 1'b1, "R11 pin pulled low by status");
    ri_en = 1'b0; step(1);
    chk(aux_ring, 1'b0, "R10 aux off when ring disabled");
    card_ring = 1'b0; step(2);
  endtask

  initial begin
    glob_rst_n = 1'b0; bus_rst_n = 1'b1; sel_ri_mode = 1'b0; ri_en = 1'b0;
    ri_to_aux = 1'b0; en_wr = 1'b0; en_wr_val = 1'b0; stat_clr = 1'b0;
    wake_req = 1'b0; card_ring = 1'b0;
    step(1);
    t_reset();
    t_ring_follow();
    t_ring_fallback();
    t_both_off();
    t_pme_mode();
    glob_reset();
    t_edge_set();
    t_w1c();
    t_bus_reset();
    t_glob_reset();
    t_aux_route();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule